// File: doc/BRIEF.md
# Dynamic Scheduling Scoreboard Controller

This block is the central hazard bookkeeping of a small out-of-order machine. The machine has two integer units, one multiplier and one divider, and eight architectural registers. Each cycle the front end may present one decoded instruction, made of a class code, a destination register and two source registers. The scoreboard either accepts the instruction into a free unit of the right class, or raises a stall. When it stalls, the front end keeps the same instruction on the inputs, so instructions still enter in program order.

Every accepted instruction then moves through four phases in its unit: issue, operand read, execute and write-back. Each phase has its own hazard check. Issue waits for a free unit and for the destination to have no pending writer (WAW). Operand read waits until both sources hold their final values (RAW). The execute phase ends when the unit's done pulse arrives. Write-back waits until no older instruction still has to read the register's old value (WAR). There is no forwarding and no renaming. The register file, the unit datapaths and the execution latencies sit outside this block. The scoreboard only produces per-unit grant strobes.

Top module: `scoreboard_ctl`

## Requirements
- R1: With `in_valid` high and no stall, `issue_grant` is one-hot in the same cycle. Class 1 goes to the multiplier (bit 2), class 2 to the divider (bit 3), and any other class to the lowest-numbered free integer unit (bits 0 and 1).
- R2: When no unit of the requested class is free, `issue_stall` is high and `issue_grant` is zero.
- R3: While any in-flight instruction targets the requested destination register, `issue_stall` is high. Issue becomes possible in the cycle after that instruction's write-back grant.
- R4: A unit asserts `read_grant` when both its sources are ready. A source counts as ready at issue if no unit is pending on it, or if its producer is granted write-back in that same issue cycle. So the earliest read comes one cycle after issue.
- R5: When a source waits on another unit, `read_grant` stays low until the cycle after that unit's write-back grant.
- R6: A unit's `read_grant` is high for exactly one cycle per instruction.
- R7: A `fu_done` pulse has an effect only while its unit is executing. At any other time it is ignored, and a later write-back still needs a fresh pulse.
- R8: Without a WAR conflict, `write_grant` is high in the cycle after the unit's `fu_done` pulse. The unit is free again in the next cycle.
- R9: `write_grant` is held low while any other unit still has to read, and has not yet read, the register the writer targets. It is released in the cycle after that read grant.
- R10: After reset all units are idle and no register is pending. `read_grant` and `write_grant` are zero, and `issue_stall` is low while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A decoded instruction is presented |
| in_cls | input | 2 | Class: 1 multiply, 2 divide, other integer |
| in_dst | input | 3 | Destination register |
| in_src1 | input | 3 | First source register |
| in_src2 | input | 3 | Second source register |
| fu_done | input | 4 | Per-unit execution-complete pulse |
| issue_stall | output | 1 | Presented instruction cannot be accepted this cycle |
| issue_grant | output | 4 | Unit receiving the presented instruction |
| read_grant | output | 4 | Unit may read its operands this cycle |
| write_grant | output | 4 | Unit may write its result this cycle |

## Verification
Some behaviours hold on every cycle, so the assertions check them all the time:
- at most one unit accepts an instruction;
- units accept only when idle and keep their class;
- every busy unit owns its destination entry in the register status table;
- a read grant never repeats;
- an executing unit without a done pulse stays executing;
- a write grant frees the unit.

The hazard orderings themselves need concrete instruction sequences, which only the bench scenarios provide. These are the RAW delay behind a producer, the WAR hold of a finished writer behind an older reader, the WAW release timing, same-cycle readiness at issue, and a stray done pulse being ignored.

// File: rtl/scoreboard_ctl.sv
module scoreboard_ctl #(
  parameter int NUM_INT  = 2,
  parameter int NUM_REGS = 8,
  parameter int CLS_W    = 2,
  localparam int NFU     = NUM_INT + 2,
  localparam int RW      = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [CLS_W-1:0] in_cls,
  input  logic [RW-1:0]    in_dst,
  input  logic [RW-1:0]    in_src1,
  input  logic [RW-1:0]    in_src2,
  input  logic [NFU-1:0]   fu_done,
  output logic             issue_stall,
  output logic [NFU-1:0]   issue_grant,
  output logic [NFU-1:0]   read_grant,
  output logic [NFU-1:0]   write_grant
);

  localparam int QW = $clog2(NFU + 1);
  localparam int QN = 1 << QW;
  localparam logic [CLS_W-1:0] CLS_MUL = CLS_W'(1);
  localparam logic [CLS_W-1:0] CLS_DIV = CLS_W'(2);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_EXEC, ST_WRITE} stage_t;

  stage_t           stg [NFU];
  logic [CLS_W-1:0] op  [NFU];
  logic [RW-1:0]    fi  [NFU];
  logic [RW-1:0]    fj  [NFU];
  logic [RW-1:0]    fk  [NFU];
  logic [QW-1:0]    qj  [NFU];
  logic [QW-1:0]    qk  [NFU];
  logic [NFU-1:0]   rj, rk;
  logic [QW-1:0]    rstat [NUM_REGS];

  logic [NFU-1:0] busy, want, free, pick, war;
  logic [QW-1:0]  pick_tag;
  logic [QN-1:0]  wb_tag;
  logic           waw, s1_rdy, s2_rdy;

  always_comb begin
    want = '0;
    if (in_cls == CLS_MUL)      want[NUM_INT]     = 1'b1;
    else if (in_cls == CLS_DIV) want[NUM_INT + 1] = 1'b1;
    else for (int i = 0; i < NUM_INT; i++) want[i] = 1'b1;
  end

  assign free = want & ~busy;
  assign pick = free & (~free + NFU'(1));

  always_comb begin
    pick_tag = '0;
    for (int i = 0; i < NFU; i++)
      if (pick[i]) pick_tag = QW'(i + 1);
  end

  assign waw         = rstat[in_dst] != '0;
  assign issue_stall = in_valid && (waw || free == '0);
  assign issue_grant = (in_valid && !waw) ? pick : '0;

  assign wb_tag = QN'({write_grant, 1'b1});
  assign s1_rdy = wb_tag[rstat[in_src1]];
  assign s2_rdy = wb_tag[rstat[in_src2]];

  always_comb begin
    for (int u = 0; u < NFU; u++) begin
      war[u] = 1'b0;
      for (int v = 0; v < NFU; v++)
        if (v != u && stg[v] == ST_READ &&
            ((rj[v] && fj[v] == fi[u]) || (rk[v] && fk[v] == fi[u])))
          war[u] = 1'b1;
    end
  end

  for (genvar g = 0; g < NFU; g++) begin : g_unit
    assign busy[g]        = stg[g] != ST_IDLE;
    assign read_grant[g]  = stg[g] == ST_READ && rj[g] && rk[g];
    assign write_grant[g] = stg[g] == ST_WRITE && !war[g];

    if (g == NUM_INT) begin : g_mul
      assert_route_mul_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy[g] |-> op[g] == CLS_MUL);
    end else if (g == NUM_INT + 1) begin : g_div
      assert_route_div_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy[g] |-> op[g] == CLS_DIV);
    end else begin : g_int
      assert_route_int_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy[g] |-> (op[g] != CLS_MUL && op[g] != CLS_DIV));
    end

    assert_issue_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      issue_grant[g] |-> !busy[g]);
    assert_dest_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy[g] |-> rstat[fi[g]] == QW'(g + 1));
    assert_read_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
      read_grant[g] |=> !read_grant[g]);
    assert_exec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stg[g] == ST_EXEC && !fu_done[g]) |=> stg[g] == ST_EXEC);
    assert_free_after_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
      write_grant[g] |=> !busy[g]);
  end

  assert_issue_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_grant));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int u = 0; u < NFU; u++) begin
        stg[u] <= ST_IDLE;
        op[u]  <= '0;
        fi[u]  <= '0;
        fj[u]  <= '0;
        fk[u]  <= '0;
        qj[u]  <= '0;
        qk[u]  <= '0;
        rj[u]  <= 1'b0;
        rk[u]  <= 1'b0;
      end
      for (int r = 0; r < NUM_REGS; r++) rstat[r] <= '0;
    end else begin
      for (int u = 0; u < NFU; u++) begin
        case (stg[u])
          ST_READ:  if (read_grant[u]) begin
                      stg[u] <= ST_EXEC;
                      rj[u]  <= 1'b0;
                      rk[u]  <= 1'b0;
                    end
          ST_EXEC:  if (fu_done[u]) stg[u] <= ST_WRITE;
          ST_WRITE: if (write_grant[u]) stg[u] <= ST_IDLE;
          default:  ;
        endcase
        for (int v = 0; v < NFU; v++)
          if (write_grant[v]) begin
            if (qj[u] == QW'(v + 1)) begin
              rj[u] <= 1'b1;
              qj[u] <= '0;
            end
            if (qk[u] == QW'(v + 1)) begin
              rk[u] <= 1'b1;
              qk[u] <= '0;
            end
          end
        if (issue_grant[u]) begin
          stg[u] <= ST_READ;
          op[u]  <= in_cls;
          fi[u]  <= in_dst;
          fj[u]  <= in_src1;
          fk[u]  <= in_src2;
          rj[u]  <= s1_rdy;
          rk[u]  <= s2_rdy;
          qj[u]  <= s1_rdy ? '0 : rstat[in_src1];
          qk[u]  <= s2_rdy ? '0 : rstat[in_src2];
        end
      end
      for (int r = 0; r < NUM_REGS; r++)
        for (int v = 0; v < NFU; v++)
          if (write_grant[v] && fi[v] == RW'(r)) rstat[r] <= '0;
      if (|issue_grant) rstat[in_dst] <= pick_tag;
    end
  end

endmodule

// File: tb/test_scoreboard_ctl.sv
module test_scoreboard_ctl;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] in_cls = '0;
  logic [2:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [3:0] fu_done = '0;
  logic       issue_stall;
  logic [3:0] issue_grant, read_grant, write_grant;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  scoreboard_ctl i_scoreboard_ctl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .fu_done(fu_done),
    .issue_stall(issue_stall), .issue_grant(issue_grant),
    .read_grant(read_grant), .write_grant(write_grant)
  );

  always #(PERIOD / 2) clk = ~clk;

  // valid, cls, dst, src1, src2, expected grant, expected stall
  localparam logic [16:0] VEC [8] = '{
    {1'b1, 2'd0, 3'd1, 3'd0, 3'd0, 4'b0001, 1'b0},
    {1'b1, 2'd3, 3'd2, 3'd1, 3'd1, 4'b0010, 1'b0},
    {1'b1, 2'd0, 3'd3, 3'd0, 3'd0, 4'b0000, 1'b1},
    {1'b1, 2'd1, 3'd1, 3'd0, 3'd0, 4'b0000, 1'b1},
    {1'b1, 2'd1, 3'd4, 3'd2, 3'd3, 4'b0100, 1'b0},
    {1'b1, 2'd2, 3'd5, 3'd4, 3'd4, 4'b1000, 1'b0},
    {1'b1, 2'd2, 3'd6, 3'd0, 3'd0, 4'b0000, 1'b1},
    {1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 4'b0000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic drive(input logic v, input logic [1:0] c, input logic [2:0] d,
                       input logic [2:0] a, input logic [2:0] b);
    in_valid = v; in_cls = c; in_dst = d; in_src1 = a; in_src2 = b;
  endtask

  task automatic do_reset();
    drive(1'b0, 2'd0, 3'd0, 3'd0, 3'd0);
    fu_done = '0;
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!finished) $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R10: reset state
    settle();
    chk("R10 stall", 32'(issue_stall), 0);
    chk("R10 read", 32'(read_grant), 0);
    chk("R10 write", 32'(write_grant), 0);

    // R1 R2 R3: routing and issue-stall table
    for (int i = 0; i < 8; i++) begin
      drive(VEC[i][16], VEC[i][15:14], VEC[i][13:11], VEC[i][10:8], VEC[i][7:5]);
      settle();
      chk("R1 R2 R3 grant", 32'(issue_grant), 32'(VEC[i][4:1]));
      chk("R2 R3 stall", 32'(issue_stall), 32'(VEC[i][0]));
      step();
    end

    // R10: reset while busy clears everything
    do_reset();
    settle();
    chk("R10 read after busy reset", 32'(read_grant), 0);
    chk("R10 write after busy reset", 32'(write_grant), 0);

    // R4 R5 R6: RAW wait behind the multiplier
    drive(1, 2'd1, 3'd1, 3'd0, 3'd0); settle();
    chk("R1 mul issue", 32'(issue_grant), 32'b0100);
    step();
    drive(1, 2'd0, 3'd2, 3'd1, 3'd1); settle();
    chk("R4 read next cycle", 32'(read_grant), 32'b0100);
    chk("R1 int issue", 32'(issue_grant), 32'b0001);
    step();
    drive(0, 0, 0, 0, 0); fu_done = 4'b0100; settle();
    chk("R5 read held", 32'(read_grant), 0);
    step();
    fu_done = 0; settle();
    chk("R8 write after done", 32'(write_grant), 32'b0100);
    chk("R5 read still held", 32'(read_grant), 0);
    step(); settle();
    chk("R5 read released", 32'(read_grant), 32'b0001);
    step(); settle();
    chk("R6 single read", 32'(read_grant), 0);

    // R9: WAR hold of a finished writer
    do_reset();
    drive(1, 2'd2, 3'd5, 3'd0, 3'd0); settle();
    chk("R1 div issue", 32'(issue_grant), 32'b1000);
    step();
    drive(1, 2'd1, 3'd4, 3'd5, 3'd6); settle();
    chk("R1 mul issue", 32'(issue_grant), 32'b0100);
    step();
    drive(1, 2'd0, 3'd6, 3'd0, 3'd0); step();
    drive(0, 0, 0, 0, 0); settle();
    chk("R4 int read", 32'(read_grant), 32'b0001);
    step();
    fu_done = 4'b0001; step();
    fu_done = 0; settle();
    chk("R9 write held", 32'(write_grant), 0);
    fu_done = 4'b1000; step();
    fu_done = 0; settle();
    chk("R8 div write", 32'(write_grant), 32'b1000);
    step(); settle();
    chk("R5 mul read", 32'(read_grant), 32'b0100);
    chk("R9 still held", 32'(write_grant), 0);
    step(); settle();
    chk("R9 released", 32'(write_grant), 32'b0001);
    step();

    // R3: WAW release timing
    do_reset();
    drive(1, 2'd0, 3'd1, 3'd0, 3'd0); step();
    drive(1, 2'd1, 3'd1, 3'd2, 3'd3); settle();
    chk("R3 stall", 32'(issue_stall), 1);
    chk("R3 no grant", 32'(issue_grant), 0);
    step();
    fu_done = 4'b0001; settle();
    chk("R3 stall exec", 32'(issue_stall), 1);
    step();
    fu_done = 0; settle();
    chk("R8 int write", 32'(write_grant), 32'b0001);
    chk("R3 stall in wb cycle", 32'(issue_stall), 1);
    step(); settle();
    chk("R3 released", 32'(issue_stall), 0);
    chk("R3 issue", 32'(issue_grant), 32'b0100);
    step();

    // R7: done outside execute is ignored
    do_reset();
    drive(1, 2'd2, 3'd2, 3'd0, 3'd0); step();
    drive(1, 2'd1, 3'd1, 3'd2, 3'd2); settle();
    chk("R4 div read", 32'(read_grant), 32'b1000);
    step();
    drive(0, 0, 0, 0, 0); fu_done = 4'b0100; step();
    fu_done = 4'b1000; settle();
    chk("R7 no write", 32'(write_grant), 0);
    chk("R7 no read", 32'(read_grant), 0);
    step();
    fu_done = 0; settle();
    chk("R8 div write", 32'(write_grant), 32'b1000);
    step(); settle();
    chk("R5 mul read", 32'(read_grant), 32'b0100);
    step(); settle();
    chk("R7 stale done ignored", 32'(write_grant), 0);
    fu_done = 4'b0100; step();
    fu_done = 0; settle();
    chk("R8 mul write", 32'(write_grant), 32'b0100);
    step();

    // R4: ready at issue when producer writes back the same cycle
    do_reset();
    drive(1, 2'd0, 3'd3, 3'd0, 3'd0); step();
    drive(0, 0, 0, 0, 0); step();
    fu_done = 4'b0001; step();
    fu_done = 0; drive(1, 2'd1, 3'd4, 3'd3, 3'd3); settle();
    chk("R8 int write", 32'(write_grant), 32'b0001);
    chk("R1 mul issue", 32'(issue_grant), 32'b0100);
    step();
    drive(0, 0, 0, 0, 0); settle();
    chk("R4 same-cycle ready", 32'(read_grant), 32'b0100);
    step();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule